// File: doc/BRIEF.md
# Bus Release Arbiter

This block sits beside a bus master's cycle sequencer and decides when the master gives the shared bus to another master and when it takes the bus back. Other masters ask for the bus on an active-low request line, which several of them may drive as a wired-OR. A request may arrive at any time, including in the middle of a bus cycle. The block answers with an active-low grant. The grant promises that the bus will be free once the current cycle ends. It does not mean that the bus is free now. The block also raises a hold line so that the sequencer starts no new cycle. It drops the output-enable of the address, data, strobe, direction and function-code drivers when the master's own cycle is over.

The block has two handover schemes. A strap sampled during reset selects one of them.
- **Three-wire scheme:** the new master takes the bus by asserting an active-low grant-acknowledge. The block accepts this only when all of the following hold at once: grant is asserted, address strobe is idle, transfer acknowledge is idle, and the local sequencer reports no cycle in progress. Because the block leaves the released state only after acknowledge has been negated, an earlier acknowledge cannot still be claiming the bus. Once the acknowledge is accepted, grant is withdrawn. One clock after the acknowledge is negated, the bus is reclaimed. If a request is still pending at that point, grant is raised again for the next requester.
- **Two-wire scheme:** the acknowledge input is ignored. The other master keeps request asserted for as long as it uses the bus, and grant stays asserted with it.

The grant, hold and driver-enable lines themselves are never tristated.

Top module: `bus_release_arbiter`

## Requirements
- R1: While reset (`rst_n` low) is asserted and on the first cycle after it: `grant_n`=1, `hold`=0, `drv_en`=1 (the block owns the bus).
- R2: While the block owns the bus, `req_n`=0 sampled at a rising edge makes `grant_n`=0 and `hold`=1 after that edge.
- R3: While grant is asserted and the bus has not yet been handed over, `drv_en` follows `cyc_busy`: drivers stay on while the local cycle runs and are off once it has ended.
- R4: In three-wire mode, an asserted `gack_n` is accepted only when grant is asserted, `as_n`=1, `dtack_n`=1 and `cyc_busy`=0 at the same edge. In any other case it is ignored: grant stays asserted while `req_n` stays 0.
- R5: After an accepted acknowledge, from the next edge: `grant_n`=1, `hold`=1, `drv_en`=0.
- R6: While released in three-wire mode, `gack_n`=1 at an edge ends the release. If `req_n`=1 at that edge, the block owns the bus again after it (`hold`=0, `drv_en`=1). If `req_n`=0, grant is asserted again instead.
- R7: If `req_n` returns to 1 while grant is asserted and before any handover, the block owns the bus again after the next edge. In three-wire mode an acknowledge accepted at the same edge takes priority over the withdrawn request.
- R8: In two-wire mode, grant leads to release at the first edge with `cyc_busy`=0 and `req_n`=0. `grant_n` stays 0 and `drv_en` stays 0 while `req_n` stays 0, and `gack_n` has no effect. `req_n`=1 at an edge returns ownership after that edge.
- R9: `two_wire` is sampled only on edges with reset asserted. Changes to it after reset have no effect until the next reset.
- R10: `hold` is 1 whenever `grant_n` is 0, and `drv_en` is 0 whenever `hold`=1 and `cyc_busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_wire | input | 1 | Scheme strap, 1 = two-wire, sampled during reset |
| req_n | input | 1 | Wired-OR bus request, active low |
| gack_n | input | 1 | Grant acknowledge from the new master, active low |
| as_n | input | 1 | Address strobe on the shared bus, active low |
| dtack_n | input | 1 | Transfer acknowledge on the shared bus, active low |
| cyc_busy | input | 1 | Local sequencer has a cycle in progress |
| grant_n | output | 1 | Bus grant, active low |
| hold | output | 1 | Sequencer must not start a new cycle |
| drv_en | output | 1 | Output enable for the tristated bus drivers |

## Verification
The hardest situation to reach from the ports is an acknowledge that arrives while grant is asserted but the bus is not yet quiet. A strobe is still active, or the local cycle is still running, and at the same time the request has already been withdrawn, or is still pending when the acknowledge later goes away. The stimulus holds request low through a long local cycle. It pulses the acknowledge with the address strobe low, then with the local cycle still running. Only then does it release both. It ends each release once with request high and once with request still low, so that both the reclaim path and the regrant path are taken. A second reset with the strap set covers the two-wire scheme. The strap is then toggled after reset to show that the scheme stays as latched.

// File: rtl/bra_pkg.sv
package bra_pkg;
  localparam int ST_W = 2;
  typedef enum logic [ST_W-1:0] {
    ST_OWN  = 2'd0,
    ST_GRNT = 2'd1,
    ST_OUT  = 2'd2
  } bra_state_e;
endpackage

// File: rtl/bra_fsm.sv
module bra_fsm
  import bra_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_q,
  input  logic       req_act,
  input  logic       gack_act,
  input  logic       bus_quiet,
  input  logic       cyc_busy,
  output bra_state_e state
);
  bra_state_e nxt;
  logic take_ok;

  assign take_ok = gack_act && bus_quiet && !cyc_busy;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OWN:  if (req_act) nxt = ST_GRNT;
      ST_GRNT: begin
        if (mode_q) begin
          if (!req_act)      nxt = ST_OWN;
          else if (!cyc_busy) nxt = ST_OUT;
        end else begin
          if (take_ok)       nxt = ST_OUT;
          else if (!req_act) nxt = ST_OWN;
        end
      end
      ST_OUT: begin
        if (mode_q) begin
          if (!req_act) nxt = ST_OWN;
        end else if (!gack_act) begin
          nxt = req_act ? ST_GRNT : ST_OWN;
        end
      end
      default: nxt = ST_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OWN;
    else        state <= nxt;
  end
endmodule

// File: rtl/bra_outdec.sv
module bra_outdec
  import bra_pkg::*;
(
  input  bra_state_e state,
  input  logic       mode_q,
  input  logic       cyc_busy,
  output logic       grant_n,
  output logic       hold,
  output logic       drv_en
);
  always_comb begin
    grant_n = !((state == ST_GRNT) || (mode_q && state == ST_OUT));
    hold    = (state != ST_OWN);
    drv_en  = (state == ST_OWN) || ((state == ST_GRNT) && cyc_busy);
  end
endmodule

// File: rtl/bus_release_arbiter.sv
module bus_release_arbiter
  import bra_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic two_wire,
  input  logic req_n,
  input  logic gack_n,
  input  logic as_n,
  input  logic dtack_n,
  input  logic cyc_busy,
  output logic grant_n,
  output logic hold,
  output logic drv_en
);
  logic       mode_q;
  bra_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= two_wire;
  end

  bra_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .req_act   (!req_n),
    .gack_act  (!gack_n),
    .bus_quiet (as_n && dtack_n),
    .cyc_busy  (cyc_busy),
    .state     (state)
  );

  bra_outdec u_dec (
    .state    (state),
    .mode_q   (mode_q),
    .cyc_busy (cyc_busy),
    .grant_n  (grant_n),
    .hold     (hold),
    .drv_en   (drv_en)
  );
endmodule

// File: rtl/bra_checker.sv
module bra_checker (
  input logic clk,
  input logic rst_n,
  input logic mode_q,
  input logic req_n,
  input logic gack_n,
  input logic as_n,
  input logic cyc_busy,
  input logic grant_n,
  input logic hold,
  input logic drv_en
);
  AST_REQ_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !req_n) |=> !grant_n); // R2
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !cyc_busy) |-> !drv_en); // R3
  AST_BAD_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !grant_n && !as_n && !req_n) |=> !grant_n); // R4
  AST_RECLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && hold && grant_n && gack_n && req_n) |=> !hold); // R6
  AST_TWO_WIRE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && hold && !req_n) |=> (hold && !grant_n)); // R8
  AST_GRANT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_n |-> hold); // R10
endmodule

bind bus_release_arbiter bra_checker u_bra_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_q   (mode_q),
  .req_n    (req_n),
  .gack_n   (gack_n),
  .as_n     (as_n),
  .cyc_busy (cyc_busy),
  .grant_n  (grant_n),
  .hold     (hold),
  .drv_en   (drv_en)
);

// File: tb/bus_release_arbiter_bench.sv
module bus_release_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic two_wire = 1'b0;
  logic req_n = 1'b1;
  logic gack_n = 1'b1;
  logic as_n = 1'b1;
  logic dtack_n = 1'b1;
  logic cyc_busy = 1'b0;
  logic grant_n, hold, drv_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model: 0 owning, 1 granted, 2 bus given away
  int   m_st = 0;
  logic m_two = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_release_arbiter u_bus_release_arbiter (
    .clk(clk), .rst_n(rst_n), .two_wire(two_wire), .req_n(req_n),
    .gack_n(gack_n), .as_n(as_n), .dtack_n(dtack_n), .cyc_busy(cyc_busy),
    .grant_n(grant_n), .hold(hold), .drv_en(drv_en)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0;
      if (clk) m_two = two_wire;
    end else begin
      case (m_st)
        0: if (req_n == 1'b0) m_st = 1;
        1: if (m_two) begin
             if (req_n) m_st = 0;
             else if (!cyc_busy) m_st = 2;
           end else begin
             if (!gack_n && as_n && dtack_n && !cyc_busy) m_st = 2;
             else if (req_n) m_st = 0;
           end
        default: if (m_two) begin
             if (req_n) m_st = 0;
           end else if (gack_n) begin
             m_st = req_n ? 0 : 1;
           end
      endcase
    end
  end

  task automatic cmp(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    logic e_g, e_h, e_d;
    cycles++;
    e_g = !((m_st == 1) || (m_two && m_st == 2));
    e_h = (m_st != 0);
    e_d = (m_st == 0) || (m_st == 1 && cyc_busy);
    cmp("grant_n", grant_n, e_g);
    cmp("hold", hold, e_h);
    cmp("drv_en", drv_en, e_d);
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // explicit point check at the next falling edge
  task automatic expect_at(input string r, input logic g, input logic h, input logic d);
    @(negedge clk); #1;
    tag = r;
    cmp("pt_grant_n", grant_n, g);
    cmp("pt_hold", hold, h);
    cmp("pt_drv_en", drv_en, d);
    step(0);
  endtask

  initial begin
    // R1: reset, three-wire strap
    tag = "R1";
    two_wire = 1'b0;
    step(3);
    expect_at("R1", 1'b1, 1'b0, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    step(1);
    expect_at("R1", 1'b1, 1'b0, 1'b1);

    // R2 / R3: request arrives during a local cycle
    tag = "R2"; cyc_busy = 1'b1; as_n = 1'b0; req_n = 1'b0;
    step(1);
    expect_at("R2", 1'b0, 1'b1, 1'b1);
    tag = "R3"; step(3);
    expect_at("R3", 1'b0, 1'b1, 1'b1);
    // R4: acknowledge while strobe active and cycle running is ignored
    tag = "R4"; gack_n = 1'b0; step(2);
    expect_at("R4", 1'b0, 1'b1, 1'b1);
    cyc_busy = 1'b0; step(2);
    expect_at("R4", 1'b0, 1'b1, 1'b0);
    dtack_n = 1'b0; as_n = 1'b1; step(2);
    expect_at("R4", 1'b0, 1'b1, 1'b0);
    // R5: all conditions met
    tag = "R5"; dtack_n = 1'b1; step(1);
    expect_at("R5", 1'b1, 1'b1, 1'b0);
    step(3);
    // R6: release with request still low -> regrant
    tag = "R6"; gack_n = 1'b1; step(1);
    expect_at("R6", 1'b0, 1'b1, 1'b0);
    gack_n = 1'b0; step(1);
    expect_at("R5", 1'b1, 1'b1, 1'b0);
    tag = "R6"; req_n = 1'b1; step(2);
    gack_n = 1'b1; step(1);
    expect_at("R6", 1'b1, 1'b0, 1'b1);
    // R7: request withdrawn before any handover
    tag = "R7"; req_n = 1'b0; cyc_busy = 1'b1; step(2);
    req_n = 1'b1; step(1);
    expect_at("R7", 1'b1, 1'b0, 1'b1);
    // R7: acknowledge beats a withdrawn request at the same edge
    req_n = 1'b0; cyc_busy = 1'b0; step(2);
    req_n = 1'b1; gack_n = 1'b0; step(1);
    expect_at("R7", 1'b1, 1'b1, 1'b0);
    gack_n = 1'b1; step(2);

    // R9 / R8: reset into two-wire mode
    tag = "R9"; rst_n = 1'b0; two_wire = 1'b1; step(2);
    @(negedge clk); rst_n = 1'b1; two_wire = 1'b0;
    step(1);
    tag = "R8"; req_n = 1'b0; cyc_busy = 1'b1; step(3);
    expect_at("R8", 1'b0, 1'b1, 1'b1);
    cyc_busy = 1'b0; step(1);
    expect_at("R8", 1'b0, 1'b1, 1'b0);
    gack_n = 1'b0; step(3);
    gack_n = 1'b1; step(2);
    expect_at("R9", 1'b0, 1'b1, 1'b0);
    req_n = 1'b1; step(1);
    expect_at("R8", 1'b1, 1'b0, 1'b1);
    tag = "R10"; req_n = 1'b0; step(4); req_n = 1'b1; step(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule